// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single programmable timer channel. Software-side logic writes its registers through a simple strobe interface: a write enable, a register select and a 32-bit data word. An interrupt-clear strobe is separate. The channel counts down once per prescaler tick while it is enabled. The tick is the clock divided by 1, 16 or 256. The count width can be 16 or 32 bits. In 16-bit mode the upper halves of the count and the reload value are kept untouched, and they remain visible on readback.

When the count reaches zero, the channel behaves according to its mode. In free-running mode it wraps to all-ones at the active width. In periodic mode it reloads from the stored reload value. In one-shot mode it stops at zero. A decrement that lands on zero raises a raw interrupt flag. That flag, gated by an enable bit, drives the masked interrupt output. The current count, the reload value and the control word are always presented on output ports. Bus decode and the merging of several channels' interrupts belong to the surrounding logic.

Top module: `pscl_down_timer`

## Requirements
- R1: After a synchronous reset the control word reads 0x20, the reload value reads 0, the count reads 0xFFFFFFFF and the raw flag is 0.
- R2: A write with select 2'b10 stores the control bits: bit0 one-shot, bit1 wide (1 = 32-bit), bits[3:2] prescale, bit5 interrupt enable, bit6 periodic, bit7 enable. Bit 4 and bits[31:8] always read zero.
- R3: Prescale code 0 gives a tick every cycle, code 1 every 16 cycles, and codes 2 and 3 every 256 cycles. The divider restarts from zero on the edge of any control write that changes the prescale field, so the first tick after such a write comes 16 or 256 edges later.
- R4: In 16-bit mode only bits[15:0] of the count change. Bits[31:16] of both the count and the reload value keep their stored contents.
- R5: In free-running mode, a tick at count zero loads all-ones into the active width: 0xFFFF in 16-bit mode, 0xFFFFFFFF in 32-bit mode.
- R6: In periodic mode, a tick at count zero loads the active-width part of the reload value.
- R7: A write with select 2'b00 sets both the reload value and the count to the data. A write with select 2'b01 sets only the reload value. Select 2'b11 has no effect. No decrement happens on the edge of a register write.
- R8: In periodic mode, a select-2'b00 write whose active-width part is zero stops counting. A select-2'b00 write whose active-width part is nonzero re-arms a halted channel.
- R9: In one-shot mode the count stays at zero after it reaches zero. A control write with the enable bit set re-arms it.
- R10: The raw flag sets on the edge where a decrement brings the active count to zero. The clear strobe resets it, but a set on the same edge takes priority. The masked output is the raw flag AND the interrupt-enable bit.
- R11: While the enable bit is 0 the count holds its value, except when a select-2'b00 write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 load+count, 01 reload only, 10 control, 11 none |
| wr_data | input | 32 | Write data |
| clr_int | input | 1 | Raw interrupt flag clear strobe |
| cur_count | output | 32 | Current count including the held upper half |
| load_rd | output | 32 | Stored reload value |
| ctrl_rd | output | 32 | Control word readback |
| raw_int | output | 1 | Raw interrupt flag |
| masked_int | output | 1 | Raw flag gated by interrupt enable |

## Verification
The properties assume that reset is asserted for at least one edge before checking begins. They also assume that wr_sel is meaningful only while wr_en is high. Two of them rely on the fact that a disabled channel can change its count only through a select-2'b00 write. The stimulus respects this: it drives every input only at the falling edge and holds reset for several cycles at the start. Random traffic uses a fixed seed. It favours prescale code 0 and small reload values so that zero crossings, wraps and reloads happen often. Directed sequences then cover the slow dividers, the one-shot halt and the zero-reload stop.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_DW = 32;
    localparam int TMR_HW = 16;

    typedef enum logic [1:0] {
        SEL_LOAD   = 2'b00,
        SEL_BGLOAD = 2'b01,
        SEL_CTRL   = 2'b10,
        SEL_NONE   = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV16  = 2'b01,
        PRE_DIV256 = 2'b10,
        PRE_RSVD   = 2'b11
    } pre_code_e;

    typedef struct packed {
        logic      enable;
        logic      periodic;
        logic      inten;
        pre_code_e pre;
        logic      wide;
        logic      oneshot;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RESET = '{enable: 1'b0, periodic: 1'b0, inten: 1'b1,
                                         pre: PRE_DIV1, wide: 1'b0, oneshot: 1'b0};

    function automatic tmr_ctrl_t ctrl_from_word(input logic [TMR_DW-1:0] w);
        tmr_ctrl_t c;
        c.enable   = w[7];
        c.periodic = w[6];
        c.inten    = w[5];
        c.pre      = pre_code_e'(w[3:2]);
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [TMR_DW-1:0] ctrl_to_word(input tmr_ctrl_t c);
        logic [TMR_DW-1:0] w;
        w      = '0;
        w[7]   = c.enable;
        w[6]   = c.periodic;
        w[5]   = c.inten;
        w[3:2] = c.pre;
        w[1]   = c.wide;
        w[0]   = c.oneshot;
        return w;
    endfunction

    function automatic logic [TMR_DW-1:0] active_mask(input logic wide);
        return wide ? {TMR_DW{1'b1}} : {{(TMR_DW-TMR_HW){1'b0}}, {TMR_HW{1'b1}}};
    endfunction

    function automatic logic [TMR_DW-1:0] merge_active(input logic [TMR_DW-1:0] held,
                                                       input logic [TMR_DW-1:0] fresh,
                                                       input logic [TMR_DW-1:0] mask);
        return (held & ~mask) | (fresh & mask);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int MID_SHIFT  = 4,
    parameter int SLOW_SHIFT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  pre_code_e code,
    output logic      tick
);
    localparam int CNT_W = SLOW_SHIFT;

    logic [CNT_W-1:0] div_cnt;
    logic             mid_hit;
    logic             slow_hit;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    generate
        if (MID_SHIFT > 0) begin : g_mid
            assign mid_hit = &div_cnt[MID_SHIFT-1:0];
        end else begin : g_mid_none
            assign mid_hit = 1'b1;
        end
    endgenerate

    assign slow_hit = &div_cnt;

    always_comb begin
        unique case (code)
            PRE_DIV1:  tick = 1'b1;
            PRE_DIV16: tick = mid_hit;
            default:   tick = slow_hit;
        endcase
    end
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [TMR_DW-1:0] wdata,
    output tmr_ctrl_t         ctrl,
    output logic              pre_restart,
    output logic              start
);
    tmr_ctrl_t next_ctrl;

    assign next_ctrl   = ctrl_from_word(wdata);
    assign pre_restart = wr && (next_ctrl.pre != ctrl.pre);
    assign start       = wr && next_ctrl.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (wr) begin
            ctrl <= next_ctrl;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tmr_ctrl_t         ctrl,
    input  logic              tick,
    input  logic              any_wr,
    input  logic              load_wr,
    input  logic              bg_wr,
    input  logic              start,
    input  logic              clr,
    input  logic [TMR_DW-1:0] wdata,
    output logic [TMR_DW-1:0] value,
    output logic [TMR_DW-1:0] load,
    output logic              raw
);
    logic [TMR_DW-1:0] mask;
    logic [TMR_DW-1:0] low;
    logic [TMR_DW-1:0] low_next;
    logic [TMR_DW-1:0] value_n;
    logic [TMR_DW-1:0] load_n;
    logic              armed;
    logic              armed_n;
    logic              step;
    logic              hit;

    assign mask = active_mask(ctrl.wide);
    assign low  = value & mask;
    assign step = ctrl.enable && armed && tick && !any_wr;

    always_comb begin
        value_n  = value;
        load_n   = load;
        armed_n  = armed;
        hit      = 1'b0;
        low_next = low;
        if (load_wr) begin
            load_n  = wdata;
            value_n = wdata;
            armed_n = ((wdata & mask) != '0) || !ctrl.periodic;
        end else begin
            if (bg_wr) begin
                load_n = wdata;
            end
            if (start) begin
                armed_n = 1'b1;
            end
            if (step) begin
                if (low != '0) begin
                    low_next = low - 1'b1;
                    if (low_next == '0) begin
                        hit = 1'b1;
                        if (ctrl.oneshot) begin
                            armed_n = 1'b0;
                        end
                    end
                end else if (ctrl.oneshot) begin
                    armed_n = 1'b0;
                end else if (ctrl.periodic) begin
                    low_next = load & mask;
                end else begin
                    low_next = mask;
                end
                value_n = merge_active(value, low_next, mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= {TMR_DW{1'b1}};
            load  <= '0;
            armed <= 1'b1;
            raw   <= 1'b0;
        end else begin
            value <= value_n;
            load  <= load_n;
            armed <= armed_n;
            if (hit) begin
                raw <= 1'b1;
            end else if (clr) begin
                raw <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pscl_down_timer.sv
module pscl_down_timer
    import tmr_pkg::*;
#(
    parameter int MID_SHIFT  = 4,
    parameter int SLOW_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [TMR_DW-1:0] wr_data,
    input  logic              clr_int,
    output logic [TMR_DW-1:0] cur_count,
    output logic [TMR_DW-1:0] load_rd,
    output logic [TMR_DW-1:0] ctrl_rd,
    output logic              raw_int,
    output logic              masked_int
);
    reg_sel_e  sel;
    tmr_ctrl_t ctrl;
    logic      ctrl_wr;
    logic      load_wr;
    logic      bg_wr;
    logic      any_wr;
    logic      pre_restart;
    logic      start;
    logic      tick;

    assign sel     = reg_sel_e'(wr_sel);
    assign ctrl_wr = wr_en && (sel == SEL_CTRL);
    assign load_wr = wr_en && (sel == SEL_LOAD);
    assign bg_wr   = wr_en && (sel == SEL_BGLOAD);
    assign any_wr  = ctrl_wr || load_wr || bg_wr;

    tmr_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr          (ctrl_wr),
        .wdata       (wr_data),
        .ctrl        (ctrl),
        .pre_restart (pre_restart),
        .start       (start)
    );

    tmr_prescaler #(
        .MID_SHIFT  (MID_SHIFT),
        .SLOW_SHIFT (SLOW_SHIFT)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (pre_restart),
        .code    (ctrl.pre),
        .tick    (tick)
    );

    tmr_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .tick    (tick),
        .any_wr  (any_wr),
        .load_wr (load_wr),
        .bg_wr   (bg_wr),
        .start   (start),
        .clr     (clr_int),
        .wdata   (wr_data),
        .value   (cur_count),
        .load    (load_rd),
        .raw     (raw_int)
    );

    assign ctrl_rd    = ctrl_to_word(ctrl);
    assign masked_int = raw_int && ctrl.inten;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        clr_int,
    input logic [31:0] cur_count,
    input logic [31:0] ctrl_rd,
    input logic        raw_int,
    input logic        masked_int,
    input logic        tick
);
    // R2: reserved control bits stay zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[31:8] == 24'd0) && !ctrl_rd[4]);

    // R3: divide-by-one produces a tick every cycle
    a_r3_div1_tick: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[3:2] == 2'b00) |-> tick);

    // R11: a disabled channel without a load write keeps its count
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rd[7] && !(wr_en && wr_sel == 2'b00)) |=> $stable(cur_count));

    // R4: upper half is held in 16-bit mode
    a_r4_upper_held: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rd[1] && !(wr_en && wr_sel == 2'b00)) |=> $stable(cur_count[31:16]));

    // R10: masked status implies raw status
    a_r10_masked_raw: assert property (@(posedge clk) disable iff (rst)
        masked_int |-> raw_int);

    // R10: clearing while disabled always empties the raw flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_int && !ctrl_rd[7]) |=> !raw_int);
endmodule

bind pscl_down_timer tmr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .clr_int    (clr_int),
    .cur_count  (cur_count),
    .ctrl_rd    (ctrl_rd),
    .raw_int    (raw_int),
    .masked_int (masked_int),
    .tick       (tick)
);

// File: tb/pscl_down_timer_bench.sv
module pscl_down_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [31:0] wr_data = '0;
    logic        clr_int = 1'b0;
    logic [31:0] cur_count, load_rd, ctrl_rd;
    logic        raw_int, masked_int;

    int total = 0;
    int bad = 0;
    bit model_on = 1'b0;

    // reference state built from the requirements
    logic [31:0] m_val, m_load, m_msk, m_lo, m_nl;
    logic [7:0]  m_ctrl, m_pc;
    logic        m_arm, m_raw, m_tk, m_hit, m_step, m_wr;

    always #5 clk = ~clk;

    pscl_down_timer u_pscl_down_timer (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .clr_int    (clr_int),
        .cur_count  (cur_count),
        .load_rd    (load_rd),
        .ctrl_rd    (ctrl_rd),
        .raw_int    (raw_int),
        .masked_int (masked_int)
    );

    function automatic logic tick_of(input logic [1:0] code, input logic [7:0] pc);
        if (code == 2'd0) return 1'b1;
        if (code == 2'd1) return pc[3:0] == 4'hF;
        return pc == 8'hFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_val = 32'hFFFF_FFFF; m_load = '0; m_ctrl = 8'h20; m_pc = '0;
            m_arm = 1'b1; m_raw = 1'b0;
        end else begin
            m_tk   = tick_of(m_ctrl[3:2], m_pc);
            m_msk  = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            m_lo   = m_val & m_msk;
            m_wr   = wr_en && (wr_sel != 2'b11);
            m_step = m_ctrl[7] && m_arm && m_tk && !m_wr;
            m_hit  = 1'b0;
            if (wr_en && wr_sel == 2'b10 && wr_data[3:2] != m_ctrl[3:2]) m_pc = '0;
            else m_pc = m_pc + 8'd1;
            if (wr_en && wr_sel == 2'b00) begin
                m_load = wr_data; m_val = wr_data;
                m_arm  = ((wr_data & m_msk) != 0) || !m_ctrl[6];
            end else if (wr_en && wr_sel == 2'b01) begin
                m_load = wr_data;
            end else if (wr_en && wr_sel == 2'b10) begin
                if (wr_data[7]) m_arm = 1'b1;
                m_ctrl = wr_data[7:0] & 8'hEF;
            end else if (m_step) begin
                if (m_lo != 0) begin
                    m_nl = m_lo - 1;
                    if (m_nl == 0) begin
                        m_hit = 1'b1;
                        if (m_ctrl[0]) m_arm = 1'b0;
                    end
                end else if (m_ctrl[0]) begin
                    m_nl = m_lo; m_arm = 1'b0;
                end else if (m_ctrl[6]) begin
                    m_nl = m_load & m_msk;
                end else begin
                    m_nl = m_msk;
                end
                m_val = (m_val & ~m_msk) | (m_nl & m_msk);
            end
            if (m_hit) m_raw = 1'b1;
            else if (clr_int) m_raw = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk("model count R4 R5 R6", cur_count, m_val);
            chk("model reload R7", load_rd, m_load);
            chk("model ctrl R2", ctrl_rd, {24'd0, m_ctrl});
            chk("model raw R10", {31'd0, raw_int}, {31'd0, m_raw});
            chk("model masked R10", {31'd0, masked_int}, {31'd0, m_raw & m_ctrl[5]});
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        clr_int = 1'b1;
        @(negedge clk);
        clr_int = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_tests();
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        cyc(4);
        @(negedge clk); rst = 1'b0;
        model_on = 1'b1;
        // R1
        chk("R1 ctrl", ctrl_rd, 32'h20);
        chk("R1 reload", load_rd, 32'h0);
        chk("R1 count", cur_count, 32'hFFFF_FFFF);
        chk("R1 raw", {31'd0, raw_int}, 32'd0);
        // R2
        wr(2'b10, 32'hFFFF_FF10);
        chk("R2 reserved", ctrl_rd, 32'h0);
        wr(2'b10, 32'h0000_006F);
        chk("R2 fields", ctrl_rd, 32'h6F);
        // R7
        wr(2'b10, 32'h02);
        wr(2'b00, 32'h1234_5678);
        chk("R7 load count", cur_count, 32'h1234_5678);
        wr(2'b01, 32'h0000_0ABC);
        chk("R7 bg reload", load_rd, 32'h0000_0ABC);
        chk("R7 bg count kept", cur_count, 32'h1234_5678);
        wr(2'b11, 32'hDEAD_BEEF);
        chk("R7 sel none", load_rd, 32'h0000_0ABC);
        // R11
        cyc(20);
        chk("R11 frozen", cur_count, 32'h1234_5678);
        // R3
        wr(2'b00, 32'd1000);
        wr(2'b10, 32'h86);
        cyc(160);
        chk("R3 div16", cur_count, 32'd990);
        wr(2'b10, 32'h8E);
        cyc(255);
        chk("R3 div256 before", cur_count, 32'd990);
        cyc(1);
        chk("R3 div256 code3", cur_count, 32'd989);
        // R9 one-shot
        wr(2'b10, 32'h02);
        wr(2'b00, 32'd3);
        wr(2'b10, 32'hA3);
        cyc(3);
        chk("R9 reach zero", cur_count, 32'd0);
        chk("R10 raw set", {31'd0, raw_int}, 32'd1);
        chk("R10 masked", {31'd0, masked_int}, 32'd1);
        cyc(10);
        chk("R9 halted", cur_count, 32'd0);
        clr_pulse();
        chk("R10 cleared", {31'd0, raw_int}, 32'd0);
        wr(2'b00, 32'd2);
        cyc(2);
        chk("R8 rearm", cur_count, 32'd0);
        chk("R8 rearm raw", {31'd0, raw_int}, 32'd1);
        wr(2'b10, 32'h83);
        chk("R10 masked off", {31'd0, masked_int}, 32'd0);
        clr_pulse();
        // R8 periodic zero stop, R6 reload
        wr(2'b10, 32'hC2);
        wr(2'b00, 32'd0);
        cyc(5);
        chk("R8 zero stop", cur_count, 32'd0);
        chk("R8 zero no raw", {31'd0, raw_int}, 32'd0);
        wr(2'b00, 32'd5);
        cyc(6);
        chk("R6 periodic reload", cur_count, 32'd5);
        // R4 R5 16-bit free run
        wr(2'b10, 32'h80);
        wr(2'b00, 32'hAAAA_0002);
        cyc(2);
        chk("R4 upper kept", cur_count, 32'hAAAA_0000);
        cyc(1);
        chk("R5 wrap 16", cur_count, 32'hAAAA_FFFF);
        wr(2'b10, 32'h82);
        wr(2'b00, 32'd1);
        cyc(2);
        chk("R5 wrap 32", cur_count, 32'hFFFF_FFFF);
        // random traffic checked by the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 8) begin
                logic [7:0] c;
                c = 8'($urandom);
                if (($urandom % 10) < 8) c[3:2] = 2'b00;
                wr(2'b10, {24'($urandom), c});
            end else if (r < 16) begin
                wr(2'b00, (($urandom % 4) == 0) ? $urandom : {16'($urandom), 16'($urandom % 40)});
            end else if (r < 20) begin
                wr(2'b01, {16'($urandom), 16'($urandom % 40)});
            end else if (r < 23) begin
                wr(2'b11, $urandom);
            end else if (r < 28) begin
                clr_pulse();
            end else begin
                cyc(1);
            end
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule